// File: doc/BRIEF.md
# Memory Bank Select Logic

This block is the part of a small 4-bit processor that decides which RAM bank answers memory and I/O commands. The processor runs in instruction cycles of eight clock phases. When a bank-designate instruction executes, the decode logic elsewhere raises `dcl_i` for that whole instruction cycle and presents a 3-bit bank code from the accumulator. The block latches the code at the end of the cycle. The choice then holds for every later memory operation until another designate instruction runs.

The block drives one program-store select line and four active-high RAM select lines. The program-store line pulses in the third phase of every cycle, which is the instruction fetch. Both kinds of line pulse in the seventh phase of any cycle that carries an address-send or memory/I/O command. Memory devices sample their select line in that phase. A full bank holds four RAM devices. With the wide-decode strap low, the four RAM lines address four banks directly. With it high, multi-bit codes drive line combinations, so a single external 3-to-8 decoder can reach eight banks.

Top module: `cmd_line_select`

## Requirements
- R1: After reset the stored selection is RAM line 0 alone, and the phase counter starts at phase index 0 in the first cycle after reset is released.
- R2: `sync_o` is high in phase index 0 of each eight-phase instruction cycle and low in the other seven phases.
- R3: `rom_sel_o` is high in phase index 2 of every instruction cycle, whatever the command inputs are.
- R4: `rom_sel_o` is high in phase index 6 exactly when `io_cmd_i` is high. It is low in every phase other than 2 and 6.
- R5: `ram_sel_o` is all zero in every phase except phase index 6. It is also all zero in phase 6 when `io_cmd_i` is low.
- R6: Code 0 drives RAM line 0 alone. A code with a single bit k set drives RAM line k+1 alone, so code 1 gives line 1, code 2 gives line 2 and code 4 gives line 3.
- R7: With `wide_decode_i` high, any nonzero code drives its bits onto lines 3..1 (code bit k goes to line k+1) and line 0 stays low. For example, code 3 drives lines 1 and 2, and code 7 drives lines 1, 2 and 3.
- R8: With `wide_decode_i` low, a designate instruction whose code has two or more bits set is ignored, and the previous selection stays in force.
- R9: A stored selection persists across any number of instruction cycles without `dcl_i`, including cycles with `io_cmd_i` low.
- R10: A designate instruction takes effect from the next instruction cycle. The phase-6 RAM pulse in the designate cycle itself still shows the previous selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase clock, one phase per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| dcl_i | input | 1 | Bank-designate instruction executing this instruction cycle |
| code_i | input | 3 | Bank code from the accumulator, valid with `dcl_i` |
| wide_decode_i | input | 1 | Strap: 1 lets multi-bit codes drive line combinations |
| io_cmd_i | input | 1 | Current instruction is an address-send or memory/I/O command |
| sync_o | output | 1 | Instruction-cycle start marker, phase index 0 |
| rom_sel_o | output | 1 | Program-store select line |
| ram_sel_o | output | 4 | RAM bank select lines |

## Verification
The properties assume that `dcl_i`, `code_i` and `io_cmd_i` change only at instruction-cycle boundaries. They also assume that `wide_decode_i` is static while a selection it produced is in force, so that the one-hot check in direct mode is meaningful. The bench drives every input just after the falling edge that starts phase 0 and holds it for the eight phases. It sweeps all codes in direct mode first and only then in wide mode, so no multi-bit selection is ever stored while the strap is low.

// File: rtl/bsel_pkg.sv
package bsel_pkg;
    localparam int PH_W     = 3;
    localparam int N_PHASES = 8;

    typedef enum logic [PH_W-1:0] {
        PH_ADR0 = 3'd0,
        PH_ADR1 = 3'd1,
        PH_ADR2 = 3'd2,
        PH_OPC0 = 3'd3,
        PH_OPC1 = 3'd4,
        PH_EXE0 = 3'd5,
        PH_EXE1 = 3'd6,
        PH_EXE2 = 3'd7
    } phase_e;

    // phase in which the program-store line is driven for instruction fetch
    localparam phase_e PH_FETCH_SEL = PH_ADR2;
    // phase in which memory devices sample their select lines
    localparam phase_e PH_BANK_SEL  = PH_EXE1;
    // final phase; the bank register loads at its closing edge
    localparam phase_e PH_FINAL     = PH_EXE2;
endpackage

// File: rtl/bsel_phase_seq.sv
module bsel_phase_seq
    import bsel_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_e phase_o,
    output logic   sync_o,
    output logic   final_o
);
    typedef struct packed {
        phase_e phase;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (seq_q.phase == PH_FINAL) begin
            seq_d.phase = PH_ADR0;
        end else begin
            seq_d.phase = phase_e'(seq_q.phase + 1'b1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.phase <= PH_ADR0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase_o = seq_q.phase;
    assign sync_o  = (seq_q.phase == PH_ADR0);
    assign final_o = (seq_q.phase == PH_FINAL);
endmodule

// File: rtl/bsel_code_map.sv
module bsel_code_map #(
    parameter int CODE_W = 3,
    localparam int LINES = CODE_W + 1
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              wide_i,
    output logic [LINES-1:0]  lines_o,
    output logic              accept_o
);
    logic multi_bit;

    // line 0 stands for the all-zero code
    assign lines_o[0] = (code_i == '0);

    // code bit k drives line k+1
    for (genvar k = 0; k < CODE_W; k++) begin : g_line
        assign lines_o[k+1] = code_i[k];
    end

    always_comb begin
        multi_bit = 1'b0;
        for (int j = 0; j < CODE_W; j++) begin
            if (code_i[j] && ((code_i & ((CODE_W'(1) << j) - CODE_W'(1))) != '0)) begin
                multi_bit = 1'b1;
            end
        end
    end

    // direct mode takes only codes that give a single line
    assign accept_o = wide_i || !multi_bit;
endmodule

// File: rtl/bsel_line_drive.sv
module bsel_line_drive
    import bsel_pkg::*;
#(
    parameter int LINES = 4
) (
    input  phase_e           phase_i,
    input  logic             io_i,
    input  logic [LINES-1:0] lines_i,
    output logic             rom_o,
    output logic [LINES-1:0] ram_o
);
    logic bank_window;

    assign bank_window = io_i && (phase_i == PH_BANK_SEL);
    assign rom_o       = (phase_i == PH_FETCH_SEL) || bank_window;

    for (genvar i = 0; i < LINES; i++) begin : g_ram
        assign ram_o[i] = bank_window && lines_i[i];
    end
endmodule

// File: rtl/cmd_line_select.sv
module cmd_line_select
    import bsel_pkg::*;
#(
    parameter int CODE_W = 3,
    localparam int LINES = CODE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dcl_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              wide_decode_i,
    input  logic              io_cmd_i,
    output logic              sync_o,
    output logic              rom_sel_o,
    output logic [LINES-1:0]  ram_sel_o
);
    typedef struct packed {
        logic [LINES-1:0] lines;
    } bank_t;

    bank_t bank_d, bank_q;

    phase_e           phase;
    logic             final_ph;
    logic [LINES-1:0] mapped;
    logic             accept;

    bsel_phase_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (phase),
        .sync_o  (sync_o),
        .final_o (final_ph)
    );

    bsel_code_map #(.CODE_W(CODE_W)) u_map (
        .code_i   (code_i),
        .wide_i   (wide_decode_i),
        .lines_o  (mapped),
        .accept_o (accept)
    );

    always_comb begin
        bank_d = bank_q;
        if (final_ph && dcl_i && accept) begin
            bank_d.lines = mapped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q.lines <= LINES'(1);
        end else begin
            bank_q <= bank_d;
        end
    end

    bsel_line_drive #(.LINES(LINES)) u_drive (
        .phase_i (phase),
        .io_i    (io_cmd_i),
        .lines_i (bank_q.lines),
        .rom_o   (rom_sel_o),
        .ram_o   (ram_sel_o)
    );
endmodule

// File: rtl/bsel_checker.sv
module bsel_checker #(
    parameter int LINES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             io_cmd_i,
    input logic             wide_decode_i,
    input logic             sync_o,
    input logic             rom_sel_o,
    input logic [LINES-1:0] ram_sel_o
);
    logic [2:0] ph;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph <= 3'd0;
        else        ph <= ph + 3'd1;
    end

    p_sync_place_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == 3'd0) |-> sync_o);
    p_sync_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |-> (ph == 3'd0));
    p_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == 3'd2) |-> rom_sel_o);
    p_rom_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ph != 3'd2 && ph != 3'd6) |-> !rom_sel_o);
    p_ram_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_sel_o != '0) |-> (ph == 3'd6 && io_cmd_i && rom_sel_o));
    p_bank_present_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == 3'd6 && io_cmd_i) |-> (rom_sel_o && ram_sel_o != '0));
    p_direct_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_decode_i |-> $onehot0(ram_sel_o));
endmodule

bind cmd_line_select bsel_checker #(.LINES(CODE_W + 1)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .io_cmd_i      (io_cmd_i),
    .wide_decode_i (wide_decode_i),
    .sync_o        (sync_o),
    .rom_sel_o     (rom_sel_o),
    .ram_sel_o     (ram_sel_o)
);

// File: tb/test_cmd_line_select.sv
module test_cmd_line_select;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 3;
    localparam int NL = CW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dcl = 1'b0;
    logic [CW-1:0] code = '0;
    logic          wide = 1'b0;
    logic          io = 1'b0;
    logic          sync;
    logic          rom;
    logic [NL-1:0] ram;

    int n_checks = 0;
    int n_fail = 0;
    logic [NL-1:0] model_lines;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_line_select #(.CODE_W(CW)) i_cmd_line_select (
        .clk           (clk),
        .rst_n         (rst_n),
        .dcl_i         (dcl),
        .code_i        (code),
        .wide_decode_i (wide),
        .io_cmd_i      (io),
        .sync_o        (sync),
        .rom_sel_o     (rom),
        .ram_sel_o     (ram)
    );

    function automatic int popcnt(input logic [CW-1:0] v);
        int c = 0;
        for (int b = 0; b < CW; b++) c += int'(v[b]);
        return c;
    endfunction

    // one instruction cycle; starts just after the falling edge of phase 0
    task automatic run_cycle(input logic d, input logic [CW-1:0] c,
                             input logic w, input logic i, input string x2_tag,
                             input bit first);
        logic [NL-1:0] nxt;
        dcl = d; code = c; wide = w; io = i;
        for (int p = 0; p < 8; p++) begin
            logic [NL+1:0] exp_v, act_v;
            string tag;
            #1;
            exp_v = {p == 0, (p == 2) || (p == 6 && i == 1'b1),
                     (p == 6 && i == 1'b1) ? model_lines : NL'(0)};
            act_v = {sync, rom, ram};
            if (first && p == 0)      tag = "R1";
            else if (p == 0)          tag = "R2";
            else if (p == 2)          tag = "R3";
            else if (p == 6)          tag = x2_tag;
            else                      tag = "R4/R5";
            n_checks++;
            if (act_v !== exp_v) begin
                n_fail++;
                $display("FAIL %s phase %0d: got sync/rom/ram=%b expected %b", tag, p, act_v, exp_v);
            end
            @(negedge clk);
        end
        if (d) begin
            nxt = NL'({c, 1'b0}) | NL'(c == '0);
            if (w || popcnt(c) <= 1) model_lines = nxt;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: got running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        model_lines = NL'(1); // R1 reset selection
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset bank seen in first memory command
        run_cycle(1'b0, '0, 1'b0, 1'b1, "R1", 1'b1);
        for (int m = 0; m < 2; m++) begin
            for (int cv = 0; cv < 8; cv++) begin
                logic [CW-1:0] c3;
                string tg;
                c3 = CW'(cv);
                // R10: designate cycle still shows old selection
                run_cycle(1'b1, c3, m[0], 1'b1, "R10", 1'b0);
                if (m == 0 && popcnt(c3) > 1) tg = "R8";
                else if (popcnt(c3) > 1)      tg = "R7";
                else                          tg = "R6";
                run_cycle(1'b0, '0, m[0], 1'b1, tg, 1'b0);
                // R5: no RAM lines without a memory command
                run_cycle(1'b0, '0, m[0], 1'b0, "R5", 1'b0);
                // R9: selection persists
                run_cycle(1'b0, ~c3, m[0], 1'b1, "R9", 1'b0);
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule